// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block carries out the processor-side work of taking an interrupt and of coming back from it. When a request is accepted, the block saves the flags word, the code segment and the instruction pointer on a stack that grows downward. It then fetches the handler pointer from a table of four-byte entries that starts at byte address zero, and loads the new code segment and instruction pointer. A return strobe runs the opposite sequence: three words are popped from the stack into the instruction pointer, the code segment and the flags.

All memory traffic goes through one 16-bit word port. The port uses a request/acknowledge handshake with at most one access in flight. The stack address is formed as segment times sixteen plus stack pointer, truncated to the address width. The stack segment is fixed by a parameter. Instruction decode, arithmetic and the handler code are outside this block. The surrounding core reads the architectural registers from the output ports.

Top module: `intEntrySeq`

## Requirements
- R1: During reset and just after it, csOut, ipOut, spOut and flagsOut hold their reset parameter values, and busy and memReq are low.
- R2: A request is taken at a clock edge where busy is low, intReq is high and the interrupt-enable flag (flags bit 9) is set. busy is high from the following cycle until the last access of the sequence is acknowledged. If intReq is taken and retReq is also high in the same cycle, intReq wins.
- R3: Entry writes three words with memWe high, in this order: flags, then CS, then IP. Each write goes to SS*16 + SP - 2, and SP drops by 2 when that write is acknowledged.
- R4: The flags word that is pushed is the value from before entry. Once that push is acknowledged, flags bits 9 (interrupt enable) and 8 (trap) read 0 and all other flag bits are unchanged.
- R5: After the pushes, the block reads the word at type*4 and then the word at type*4+2. When the second read is acknowledged, ipOut takes the first word and csOut takes the second word, in the same cycle.
- R6: intReq and retReq have no effect while busy is high. intReq also has no effect while flags bit 9 is clear.
- R7: When busy is low and no interrupt is being taken, retReq starts a return. The return reads from SS*16 + SP three times, loading IP, then CS, then flags, and SP rises by 2 after each acknowledged read.
- R8: While memReq is high and memAck is low, memReq, memAddr, memWe and memWdata hold steady. Each acknowledge completes exactly one access. memReq is low whenever busy is low.
- R9: SP wraps modulo 2^16, and the 20-bit address SS*16 + SP wraps modulo 2^20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| intReq | input | 1 | Maskable interrupt request |
| intType | input | 8 | Interrupt type sampled with intReq |
| retReq | input | 1 | Request to return from a handler |
| busy | output | 1 | Entry or return sequence in progress |
| csOut | output | 16 | Code segment register |
| ipOut | output | 16 | Instruction pointer register |
| spOut | output | 16 | Stack pointer register |
| flagsOut | output | 16 | Flags register |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | 20 | Byte address of the word access |
| memWdata | output | 16 | Write data |
| memRdata | input | 16 | Read data, valid with memAck |
| memAck | input | 1 | Access completes at this edge |

## Verification
The bench sends requests while a sequence is running and while interrupts are masked. A design that did not ignore these would start a second sequence or corrupt the saved state. It raises intReq and retReq in the same cycle, where swapping the priority would pop the stack instead of pushing to it. It uses vector types 0 and 255, which would expose an error in the type*4 scaling or in the +2 offset. The stack segment is placed near the top of the address space and SP near zero, so an address or pointer computed without the wrap of R9 would miss the expected location. Acknowledge latencies vary, so a design that moved on without an acknowledge, or changed its outputs while waiting, would break the push and pop order.

// File: rtl/intseq_pkg.sv
package intseq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH_FL,
    ST_PUSH_CS,
    ST_PUSH_IP,
    ST_VEC_IP,
    ST_VEC_CS,
    ST_POP_IP,
    ST_POP_CS,
    ST_POP_FL
  } seqState_t;

  typedef enum logic [1:0] {
    WS_FLAGS,
    WS_CS,
    WS_IP
  } wrSrc_t;

  // strobes from control to datapath; *Done style fields fire on the acknowledge edge only
  typedef struct packed {
    logic   stackSel;   // address comes from the stack, not the vector table
    logic   pushMode;   // stack address uses SP - word size
    logic   vecHi;      // upper half of the vector entry
    wrSrc_t wrSrc;      // which register feeds the write data
    logic   latchType;  // capture the interrupt type
    logic   commit;     // current access acknowledged
    logic   clrMask;    // clear interrupt-enable and trap flags
    logic   ldOffset;   // keep the fetched offset
    logic   ldVector;   // load CS from read data, IP from kept offset
    logic   popIp;
    logic   popCs;
    logic   popFlags;
  } seqCtl_t;

endpackage

// File: rtl/intseq_ctrl.sv
module intseq_ctrl
  import intseq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    intReq,
  input  logic    retReq,
  input  logic    intEnable,
  input  logic    memAck,
  output seqCtl_t ctl,
  output logic    memReq,
  output logic    memWe,
  output logic    busy
);

  seqState_t state;
  seqState_t nextState;
  logic      accept;
  logic      startRet;
  logic      done;

  function automatic seqState_t succ(input seqState_t s);
    case (s)
      ST_PUSH_FL: return ST_PUSH_CS;
      ST_PUSH_CS: return ST_PUSH_IP;
      ST_PUSH_IP: return ST_VEC_IP;
      ST_VEC_IP:  return ST_VEC_CS;
      ST_POP_IP:  return ST_POP_CS;
      ST_POP_CS:  return ST_POP_FL;
      default:    return ST_IDLE;
    endcase
  endfunction

  always_comb begin
    accept   = (state == ST_IDLE) && intReq && intEnable;
    startRet = (state == ST_IDLE) && !accept && retReq;
    memReq   = (state != ST_IDLE);
    busy     = (state != ST_IDLE);
    done     = memReq && memAck;
  end

  always_comb begin
    if (state == ST_IDLE) begin
      if (accept)        nextState = ST_PUSH_FL;
      else if (startRet) nextState = ST_POP_IP;
      else               nextState = ST_IDLE;
    end else if (memAck) begin
      nextState = succ(state);
    end else begin
      nextState = state;
    end
  end

  always_comb begin
    ctl           = '0;
    memWe         = 1'b0;
    ctl.latchType = accept;
    ctl.commit    = done;
    case (state)
      ST_PUSH_FL: begin
        memWe        = 1'b1;
        ctl.stackSel = 1'b1;
        ctl.pushMode = 1'b1;
        ctl.wrSrc    = WS_FLAGS;
        ctl.clrMask  = done;
      end
      ST_PUSH_CS: begin
        memWe        = 1'b1;
        ctl.stackSel = 1'b1;
        ctl.pushMode = 1'b1;
        ctl.wrSrc    = WS_CS;
      end
      ST_PUSH_IP: begin
        memWe        = 1'b1;
        ctl.stackSel = 1'b1;
        ctl.pushMode = 1'b1;
        ctl.wrSrc    = WS_IP;
      end
      ST_VEC_IP: begin
        ctl.ldOffset = done;
      end
      ST_VEC_CS: begin
        ctl.vecHi    = 1'b1;
        ctl.ldVector = done;
      end
      ST_POP_IP: begin
        ctl.stackSel = 1'b1;
        ctl.popIp    = done;
      end
      ST_POP_CS: begin
        ctl.stackSel = 1'b1;
        ctl.popCs    = done;
      end
      ST_POP_FL: begin
        ctl.stackSel = 1'b1;
        ctl.popFlags = done;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

endmodule

// File: rtl/intseq_dpath.sv
module intseq_dpath
  import intseq_pkg::*;
#(
  parameter int              DATA_W      = 16,
  parameter int              ADDR_W      = 20,
  parameter int              TYPE_W      = 8,
  parameter int              SEG_SHIFT   = 4,
  parameter int              IE_BIT      = 9,
  parameter int              TRAP_BIT    = 8,
  parameter logic [DATA_W-1:0] STACK_SEG   = '0,
  parameter logic [DATA_W-1:0] RESET_CS    = '0,
  parameter logic [DATA_W-1:0] RESET_IP    = '0,
  parameter logic [DATA_W-1:0] RESET_SP    = '0,
  parameter logic [DATA_W-1:0] RESET_FLAGS = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [TYPE_W-1:0] intType,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] csOut,
  output logic [DATA_W-1:0] ipOut,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] flagsOut,
  output logic              intEnable
);

  localparam int              BYTES     = DATA_W / 8;
  localparam int              VEC_SHIFT = $clog2(2 * BYTES);
  localparam logic [DATA_W-1:0] STEP    = DATA_W'(BYTES);
  localparam logic [DATA_W-1:0] CLR_MASK =
    ~((DATA_W'(1) << IE_BIT) | (DATA_W'(1) << TRAP_BIT));
  localparam logic [ADDR_W-1:0] SEG_BASE = ADDR_W'(STACK_SEG) << SEG_SHIFT;

  logic [DATA_W-1:0] csReg, ipReg, spReg, flagsReg, offTmp;
  logic [TYPE_W-1:0] vecType;
  logic [DATA_W-1:0] spEff;
  logic [ADDR_W-1:0] stackAddr, vecAddr;

  always_comb begin
    spEff     = ctl.pushMode ? (spReg - STEP) : spReg;
    stackAddr = SEG_BASE + ADDR_W'(spEff);
    vecAddr   = (ADDR_W'(vecType) << VEC_SHIFT) + (ctl.vecHi ? ADDR_W'(BYTES) : '0);
    memAddr   = ctl.stackSel ? stackAddr : vecAddr;
    case (ctl.wrSrc)
      WS_CS:   memWdata = csReg;
      WS_IP:   memWdata = ipReg;
      default: memWdata = flagsReg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csReg    <= RESET_CS;
      ipReg    <= RESET_IP;
      spReg    <= RESET_SP;
      flagsReg <= RESET_FLAGS;
      offTmp   <= '0;
      vecType  <= '0;
    end else begin
      if (ctl.latchType) vecType <= intType;
      if (ctl.commit && ctl.stackSel)
        spReg <= ctl.pushMode ? (spReg - STEP) : (spReg + STEP);
      if (ctl.clrMask)       flagsReg <= flagsReg & CLR_MASK;
      else if (ctl.popFlags) flagsReg <= memRdata;
      if (ctl.ldOffset) offTmp <= memRdata;
      if (ctl.ldVector) begin
        csReg <= memRdata;
        ipReg <= offTmp;
      end
      if (ctl.popIp) ipReg <= memRdata;
      if (ctl.popCs) csReg <= memRdata;
    end
  end

  assign csOut     = csReg;
  assign ipOut     = ipReg;
  assign spOut     = spReg;
  assign flagsOut  = flagsReg;
  assign intEnable = flagsReg[IE_BIT];

endmodule

// File: rtl/intEntrySeq.sv
module intEntrySeq
  import intseq_pkg::*;
#(
  parameter int              DATA_W      = 16,
  parameter int              ADDR_W      = 20,
  parameter int              TYPE_W      = 8,
  parameter int              SEG_SHIFT   = 4,
  parameter int              IE_BIT      = 9,
  parameter int              TRAP_BIT    = 8,
  parameter logic [DATA_W-1:0] STACK_SEG   = 16'h0000,
  parameter logic [DATA_W-1:0] RESET_CS    = 16'hF000,
  parameter logic [DATA_W-1:0] RESET_IP    = 16'hFFF0,
  parameter logic [DATA_W-1:0] RESET_SP    = 16'h0400,
  parameter logic [DATA_W-1:0] RESET_FLAGS = 16'h0202
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              intReq,
  input  logic [TYPE_W-1:0] intType,
  input  logic              retReq,
  output logic              busy,
  output logic [DATA_W-1:0] csOut,
  output logic [DATA_W-1:0] ipOut,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] flagsOut,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck
);

  seqCtl_t ctl;
  logic    intEnable;

  intseq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .intReq    (intReq),
    .retReq    (retReq),
    .intEnable (intEnable),
    .memAck    (memAck),
    .ctl       (ctl),
    .memReq    (memReq),
    .memWe     (memWe),
    .busy      (busy)
  );

  intseq_dpath #(
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .TYPE_W      (TYPE_W),
    .SEG_SHIFT   (SEG_SHIFT),
    .IE_BIT      (IE_BIT),
    .TRAP_BIT    (TRAP_BIT),
    .STACK_SEG   (STACK_SEG),
    .RESET_CS    (RESET_CS),
    .RESET_IP    (RESET_IP),
    .RESET_SP    (RESET_SP),
    .RESET_FLAGS (RESET_FLAGS)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .intType   (intType),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .csOut     (csOut),
    .ipOut     (ipOut),
    .spOut     (spOut),
    .flagsOut  (flagsOut),
    .intEnable (intEnable)
  );

endmodule

// File: rtl/intseq_checker.sv
module intseq_checker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 20,
  parameter int IE_BIT = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              intReq,
  input logic              retReq,
  input logic              busy,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic [DATA_W-1:0] csOut,
  input logic [DATA_W-1:0] ipOut,
  input logic [DATA_W-1:0] spOut,
  input logic [DATA_W-1:0] flagsOut
);

  p_hold_req_r8: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq && !memWe);

  p_start_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(intReq || retReq));

  p_ie_drop_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagsOut[IE_BIT]) |-> $past(memReq && memAck));

  p_regs_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && memAck) |=> $stable(csOut) && $stable(ipOut) && $stable(spOut) && $stable(flagsOut));

  p_sp_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memAck |=> (spOut == $past(spOut) - DATA_W'(2)) ||
                         (spOut == $past(spOut) + DATA_W'(2)) || $stable(spOut));

endmodule

bind intEntrySeq intseq_checker #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .IE_BIT (IE_BIT)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .intReq   (intReq),
  .retReq   (retReq),
  .busy     (busy),
  .memReq   (memReq),
  .memWe    (memWe),
  .memAck   (memAck),
  .memAddr  (memAddr),
  .memWdata (memWdata),
  .csOut    (csOut),
  .ipOut    (ipOut),
  .spOut    (spOut),
  .flagsOut (flagsOut)
);

// File: tb/intEntrySeq_bench.sv
module intEntrySeq_bench;

  localparam int          CLK_PERIOD = 10;
  localparam logic [15:0] SEG  = 16'hFFF8;
  localparam logic [15:0] R_CS = 16'h1234;
  localparam logic [15:0] R_IP = 16'h0100;
  localparam logic [15:0] R_SP = 16'h0004;
  localparam logic [15:0] R_FL = 16'h0302;

  logic        clk = 1'b0;
  logic        rstN;
  logic        intReq, retReq, memAck;
  logic [7:0]  intType;
  logic        busy, memReq, memWe;
  logic [15:0] csOut, ipOut, spOut, flagsOut, memWdata, memRdata;
  logic [19:0] memAddr;

  intEntrySeq #(
    .STACK_SEG (SEG), .RESET_CS (R_CS), .RESET_IP (R_IP),
    .RESET_SP (R_SP), .RESET_FLAGS (R_FL)
  ) u_intEntrySeq (
    .clk (clk), .rstN (rstN), .intReq (intReq), .intType (intType),
    .retReq (retReq), .busy (busy), .csOut (csOut), .ipOut (ipOut),
    .spOut (spOut), .flagsOut (flagsOut), .memReq (memReq), .memWe (memWe),
    .memAddr (memAddr), .memWdata (memWdata), .memRdata (memRdata), .memAck (memAck)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  string ctx    = "R1";

  // reference model state
  logic [15:0] mCs, mIp, mSp, mFl, mOff;
  logic [7:0]  mType;
  logic        mBusy;
  int          opQ[$];
  logic [15:0] mem[int];

  // stimulus and bus-side state
  logic        drvInt = 1'b0, drvRet = 1'b0;
  logic [7:0]  drvType = 8'h00;
  logic        sReq, sWe, ackD;
  logic [19:0] sAddr;
  logic [15:0] sWd, rdD;
  logic [7:0]  lfsr = 8'hA5;
  int          waitLeft = 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", ctx, tag, act, exp);
    end
  endtask

  function automatic logic [15:0] memRead(input int a);
    if (mem.exists(a)) return mem[a];
    return 16'(a) ^ 16'h5A3C;
  endfunction

  // R9: stack address wraps in 20 bits
  function automatic logic [19:0] stackAddr(input logic [15:0] sp);
    return {SEG, 4'b0} + {4'b0, sp};
  endfunction

  task automatic doOp();
    int          op;
    logic [19:0] expA;
    logic        expW;
    op = opQ.pop_front();
    expW = (op < 3);
    case (op)
      0, 1, 2: begin
        mSp  = mSp - 16'd2;
        expA = stackAddr(mSp);
        chk("R3 push addr", 32'(sAddr), 32'(expA));
        chk("R3 push data", 32'(sWd), (op == 0) ? 32'(mFl) : (op == 1) ? 32'(mCs) : 32'(mIp));
        mem[int'(sAddr)] = sWd;
        if (op == 0) mFl = mFl & 16'hFCFF;
      end
      3: begin
        expA = 20'(mType) * 20'd4;
        chk("R5 vector offset addr", 32'(sAddr), 32'(expA));
        mOff = rdD;
      end
      4: begin
        expA = 20'(mType) * 20'd4 + 20'd2;
        chk("R5 vector segment addr", 32'(sAddr), 32'(expA));
        mCs = rdD;
        mIp = mOff;
      end
      default: begin
        expA = stackAddr(mSp);
        chk("R7 pop addr", 32'(sAddr), 32'(expA));
        if (op == 5) mIp = rdD;
        else if (op == 6) mCs = rdD;
        else mFl = rdD;
        mSp = mSp + 16'd2;
      end
    endcase
    chk("R3/R7 write enable", 32'(sWe), 32'(expW));
    if (opQ.size() == 0) mBusy = 1'b0;
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic cycle();
    chk("R2 busy", 32'(busy), 32'(mBusy));
    chk("R5/R7 cs", 32'(csOut), 32'(mCs));
    chk("R5/R7 ip", 32'(ipOut), 32'(mIp));
    chk("R3/R9 sp", 32'(spOut), 32'(mSp));
    chk("R4/R7 flags", 32'(flagsOut), 32'(mFl));
    sReq = memReq; sWe = memWe; sAddr = memAddr; sWd = memWdata;
    ackD = 1'b0;
    if (sReq) begin
      if (waitLeft == 0) begin
        ackD     = 1'b1;
        rdD      = sWe ? 16'h0000 : memRead(int'(sAddr));
        lfsr     = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        waitLeft = int'(lfsr[1:0]);
      end else begin
        waitLeft--;
      end
    end
    memAck   = ackD;
    memRdata = rdD;
    intReq   = drvInt;
    intType  = drvType;
    retReq   = drvRet;
    @(posedge clk);
    if (sReq && !mBusy) chk("R8 request while idle", 32'(sReq), 32'd0);
    if (mBusy && sReq && ackD) doOp();
    else if (!mBusy) begin
      if (drvInt && mFl[9]) begin
        mType = drvType;
        opQ.delete();
        for (int k = 0; k < 5; k++) opQ.push_back(k);
        mBusy = 1'b1;
      end else if (drvRet) begin
        opQ.delete();
        for (int k = 5; k < 8; k++) opQ.push_back(k);
        mBusy = 1'b1;
      end
    end
    @(negedge clk);
  endtask

  task automatic waitIdle();
    for (int n = 0; n < 200; n++) begin
      cycle();
      if (!mBusy) break;
    end
  endtask

  task automatic takeInt(input logic [7:0] t);
    drvInt = 1'b1; drvType = t;
    cycle();
    drvInt = 1'b0;
    waitIdle();
  endtask

  task automatic doReturn();
    drvRet = 1'b1;
    cycle();
    drvRet = 1'b0;
    waitIdle();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0; intReq = 1'b0; retReq = 1'b0; intType = 8'h00;
    memAck = 1'b0; memRdata = 16'h0000; rdD = 16'h0000;
    mCs = R_CS; mIp = R_IP; mSp = R_SP; mFl = R_FL; mOff = 16'h0; mType = 8'h0; mBusy = 1'b0;
    repeat (4) @(negedge clk);
    ctx = "R1 reset";
    chk("R1 cs", 32'(csOut), 32'(R_CS));
    chk("R1 ip", 32'(ipOut), 32'(R_IP));
    chk("R1 sp", 32'(spOut), 32'(R_SP));
    chk("R1 flags", 32'(flagsOut), 32'(R_FL));
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 memReq", 32'(memReq), 32'd0);
    rstN = 1'b1;
    cycle();

    // entry that crosses SP zero and the 20-bit address top (R9), stray requests while busy (R6)
    ctx = "R3/R4/R5/R9 entry type 8";
    drvInt = 1'b1; drvType = 8'h08;
    cycle();
    ctx = "R6 requests during sequence";
    drvType = 8'h03; drvRet = 1'b1;
    waitIdle();
    drvInt = 1'b0; drvRet = 1'b0;
    cycle();

    // masked request ignored (R6)
    ctx = "R6 masked request";
    drvInt = 1'b1; drvType = 8'h05;
    for (int i = 0; i < 6; i++) cycle();
    drvInt = 1'b0;

    // return restores state, unmasks (R7, R9)
    ctx = "R7/R9 return";
    doReturn();
    cycle();

    // simultaneous requests: interrupt wins (R2)
    ctx = "R2 priority";
    drvInt = 1'b1; drvRet = 1'b1; drvType = 8'h00;
    cycle();
    drvInt = 1'b0; drvRet = 1'b0;
    waitIdle();
    ctx = "R7 return after type 0";
    doReturn();

    // highest vector type (R5)
    ctx = "R5 type 255";
    takeInt(8'hFF);
    ctx = "R7 return after type 255";
    doReturn();

    // back-to-back sequence with handshake stalls (R8)
    ctx = "R8 handshake type 0x21";
    takeInt(8'h21);
    ctx = "R7 return after 0x21";
    doReturn();
    ctx = "R7 extra return";
    doReturn();
    for (int i = 0; i < 3; i++) cycle();

    summary();
    $finish;
  end

endmodule